// File: doc/BRIEF.md
# Laser Bias Controller with Safety Shutdown

This block is the digital side of a laser transmitter's bias control. A sampled monitor-power code comes in from the monitor photodiode path, and a bias-current code goes out to the bias DAC. The controller runs a slow closed loop. At each update it moves the bias by one code toward the point where monitored power matches a programmed target. A small deadband around the target stops the loop from dithering. Temperature and aging drift are tracked in this way.

The same update instants also feed a safety guard. If the bias code goes above its trip limit, or the monitor power goes above its trip limit, on two updates in a row, a fault latches. The laser is then switched off, and only an active-low reset clears the fault. A disable input turns the laser off at any time and never creates a fault. A separate alarm that does not latch reports when the bias code leaves a normal operating window, so that aging can be watched.

Top module: `laser_bias_ctrl`

## Requirements
- R1: The loop updates once every UPDATE_DIV clock cycles (default 16). The update cycle is the 16th rising edge after reset release and every 16th edge after that. Between updates the bias code does not change unless the loop is held.
- R2: At an update the loop compares monitor power (mon) with the target (tgt). If mon + 1 < tgt, the bias rises by one. If mon > tgt + 1, the bias falls by one. Otherwise the bias stays where it is.
- R3: While rst_n is low, the bias code is 0, the fault flag is 0 and laser_en is 0.
- R4: While laser_off is high, laser_en is 0 in the same cycle and the bias code is 0 from the next clock edge. The loop is frozen during this time. After release the bias ramps up from 0.
- R5: An over-limit sample is one where bias > bias_trip or mon > pwr_trip. The fault flag sets at the second consecutive update that sees an over-limit sample. A single over-limit update followed by a clean update does not set it.
- R6: Once set, the fault flag stays at 1 until rst_n goes low. While the fault is set, laser_en is 0 and the bias code is held at 0.
- R7: While laser_off is high, over-limit samples are not evaluated and the count of consecutive over-limit updates is cleared. Disabling the laser therefore never sets the fault.
- R8: bias_alarm is 1 exactly when the bias code is below win_lo or above win_hi. It is computed from the current bias code and does not latch.
- R9: The bias code saturates: it stays at all-ones when asked to rise and stays at 0 when asked to fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-on or strobe), asynchronous assert |
| laser_off | input | 1 | Forces the laser off and freezes the loop |
| mon_pwr | input | PWR_W | Sampled monitor-power code |
| pwr_tgt | input | PWR_W | Power setpoint |
| bias_trip | input | CODE_W | Bias trip limit (strictly greater than trips) |
| pwr_trip | input | PWR_W | Power trip limit (strictly greater than trips) |
| win_lo | input | CODE_W | Lower edge of the normal bias window |
| win_hi | input | CODE_W | Upper edge of the normal bias window |
| bias_code | output | CODE_W | Bias-current code to the DAC |
| laser_en | output | 1 | Laser enable |
| fault | output | 1 | Latched safety fault |
| bias_alarm | output | 1 | Bias outside the normal window |

## Verification
Bias and fault are registered. A change made at an update edge is therefore seen at the falling edge after that rising edge, and the bench reference model advances on the same rising edge. laser_en and bias_alarm are combinational from rst_n, laser_off, the fault register and the bias register. A change on laser_off shows on laser_en within the same cycle, while the bias drops to 0 one edge later. The bench steps its model at every rising edge, compares all four outputs at every falling edge, and changes stimulus only after that comparison. Glitch tests are placed by waiting until the model's update counter shows that the next edge is an update edge.

// File: rtl/lbc_pkg.sv
package lbc_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  // Direction of one loop step, with a symmetric deadband around target
  function automatic step_e pick_step(int unsigned mon, int unsigned tgt,
                                      int unsigned band);
    if (mon + band < tgt) return STEP_UP;
    if (mon > tgt + band) return STEP_DOWN;
    return STEP_HOLD;
  endfunction

  // True when either quantity is strictly above its trip limit
  function automatic logic over_limit(int unsigned bias, int unsigned bias_lim,
                                      int unsigned pwr, int unsigned pwr_lim);
    return (bias > bias_lim) || (pwr > pwr_lim);
  endfunction

  // True when a code lies outside an inclusive window
  function automatic logic out_of_window(int unsigned code, int unsigned lo,
                                         int unsigned hi);
    return (code < lo) || (code > hi);
  endfunction

endpackage

// File: rtl/lbc_update_timer.sv
module lbc_update_timer #(
  parameter int unsigned DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lbc_bias_loop.sv
module lbc_bias_loop
  import lbc_pkg::*;
#(
  parameter int unsigned CODE_W = 10,
  parameter int unsigned PWR_W  = 10,
  parameter int unsigned BAND   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              tick,
  input  logic [PWR_W-1:0]  mon_pwr,
  input  logic [PWR_W-1:0]  pwr_tgt,
  output step_e             dir,
  output logic [CODE_W-1:0] bias_q
);
  localparam logic [CODE_W-1:0] TOP = '1;

  assign dir = pick_step(32'(mon_pwr), 32'(pwr_tgt), BAND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bias_q <= '0;
    end else if (hold) begin
      bias_q <= '0;
    end else if (tick) begin
      case (dir)
        STEP_UP:   if (bias_q != TOP) bias_q <= bias_q + 1'b1;
        STEP_DOWN: if (bias_q != '0)  bias_q <= bias_q - 1'b1;
        default:   bias_q <= bias_q;
      endcase
    end
  end
endmodule

// File: rtl/lbc_trip_guard.sv
module lbc_trip_guard
  import lbc_pkg::*;
#(
  parameter int unsigned CODE_W  = 10,
  parameter int unsigned PWR_W   = 10,
  parameter int unsigned STRIKES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              laser_off,
  input  logic              tick,
  input  logic [CODE_W-1:0] bias,
  input  logic [PWR_W-1:0]  mon_pwr,
  input  logic [CODE_W-1:0] bias_trip,
  input  logic [PWR_W-1:0]  pwr_trip,
  output logic              over_hit,
  output logic              last_strike,
  output logic              fault_q
);
  localparam int unsigned SW = $clog2(STRIKES + 1);
  localparam logic [SW-1:0] ARM = SW'(STRIKES - 1);

  logic [SW-1:0] strikes_q;
  logic          eval;

  assign over_hit    = over_limit(32'(bias), 32'(bias_trip), 32'(mon_pwr), 32'(pwr_trip));
  assign last_strike = (strikes_q >= ARM);
  assign eval        = tick && !laser_off && !fault_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strikes_q <= '0;
      fault_q   <= 1'b0;
    end else if (laser_off) begin
      strikes_q <= '0;
    end else if (eval) begin
      if (over_hit) begin
        if (last_strike) fault_q <= 1'b1;
        else             strikes_q <= strikes_q + 1'b1;
      end else begin
        strikes_q <= '0;
      end
    end
  end
endmodule

// File: rtl/laser_bias_ctrl.sv
module laser_bias_ctrl
  import lbc_pkg::*;
#(
  parameter int unsigned CODE_W     = 10,
  parameter int unsigned PWR_W      = 10,
  parameter int unsigned UPDATE_DIV = 16,
  parameter int unsigned BAND       = 1,
  parameter int unsigned STRIKES    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              laser_off,
  input  logic [PWR_W-1:0]  mon_pwr,
  input  logic [PWR_W-1:0]  pwr_tgt,
  input  logic [CODE_W-1:0] bias_trip,
  input  logic [PWR_W-1:0]  pwr_trip,
  input  logic [CODE_W-1:0] win_lo,
  input  logic [CODE_W-1:0] win_hi,
  output logic [CODE_W-1:0] bias_code,
  output logic              laser_en,
  output logic              fault,
  output logic              bias_alarm
);
  // Internal events brought out by name for the checker
  logic  tick;
  logic  hold;
  logic  over_hit;
  logic  last_strike;
  step_e dir;

  assign hold = laser_off || fault;

  lbc_update_timer #(.DIV(UPDATE_DIV)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  lbc_bias_loop #(.CODE_W(CODE_W), .PWR_W(PWR_W), .BAND(BAND)) u_loop (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold    (hold),
    .tick    (tick),
    .mon_pwr (mon_pwr),
    .pwr_tgt (pwr_tgt),
    .dir     (dir),
    .bias_q  (bias_code)
  );

  lbc_trip_guard #(.CODE_W(CODE_W), .PWR_W(PWR_W), .STRIKES(STRIKES)) u_guard (
    .clk         (clk),
    .rst_n       (rst_n),
    .laser_off   (laser_off),
    .tick        (tick),
    .bias        (bias_code),
    .mon_pwr     (mon_pwr),
    .bias_trip   (bias_trip),
    .pwr_trip    (pwr_trip),
    .over_hit    (over_hit),
    .last_strike (last_strike),
    .fault_q     (fault)
  );

  assign laser_en   = rst_n && !laser_off && !fault;
  assign bias_alarm = out_of_window(32'(bias_code), 32'(win_lo), 32'(win_hi));
endmodule

// File: rtl/lbc_checker.sv
module lbc_checker #(
  parameter int unsigned CODE_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              laser_off,
  input logic              tick,
  input logic              hold,
  input logic              over_hit,
  input logic              last_strike,
  input logic              fault,
  input logic              laser_en,
  input logic [CODE_W-1:0] bias_code
);
  // R3: no light while reset is held
  always_comb begin
    if (!rst_n) begin
      a_r3_dark_in_reset: assert (!laser_en) else $error("R3 laser_en high in reset");
    end
  end

  // R1: bias only moves on an update edge or when held
  a_r1_still_between_updates: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !hold) |=> $stable(bias_code));

  // R2: one update moves the bias by at most one code
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !hold) |=> (bias_code == $past(bias_code) ||
                         bias_code == $past(bias_code) + 1'b1 ||
                         bias_code == $past(bias_code) - 1'b1));

  // R4: disable darkens at once and zeroes bias next edge
  a_r4_off_dark: assert property (@(posedge clk) disable iff (!rst_n)
    laser_off |-> !laser_en);
  a_r4_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
    laser_off |=> (bias_code == '0));

  // R5: fault rises only after an armed over-limit update
  a_r5_two_strikes: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> $past(tick && over_hit && last_strike));

  // R6: fault holds and keeps the laser dark
  a_r6_latched: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);
  a_r6_dark: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !laser_en);

  // R7: disabling never produces a fault
  a_r7_no_fault_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    laser_off |=> !$rose(fault));
endmodule

bind laser_bias_ctrl lbc_checker #(.CODE_W(CODE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .laser_off   (laser_off),
  .tick        (tick),
  .hold        (hold),
  .over_hit    (over_hit),
  .last_strike (last_strike),
  .fault       (fault),
  .laser_en    (laser_en),
  .bias_code   (bias_code)
);

// File: tb/laser_bias_ctrl_test.sv
`timescale 1ns/1ps
module laser_bias_ctrl_test;
  localparam int CW = 10;
  localparam int PW = 10;
  localparam int DIV = 16;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic laser_off = 1'b0;
  logic [PW-1:0] mon_pwr = '0;
  logic [PW-1:0] pwr_tgt = '0;
  logic [CW-1:0] bias_trip = '1;
  logic [PW-1:0] pwr_trip = '1;
  logic [CW-1:0] win_lo = 10'd100;
  logic [CW-1:0] win_hi = 10'd900;
  logic [CW-1:0] bias_code;
  logic laser_en, fault, bias_alarm;

  int errors = 0;
  int checks = 0;
  bit plant = 1'b0;
  bit done = 1'b0;

  // reference model state
  int m_cnt = 0, m_bias = 0, m_str = 0;
  bit m_fault = 1'b0;

  always #10 clk = ~clk;

  laser_bias_ctrl uut (
    .clk(clk), .rst_n(rst_n), .laser_off(laser_off), .mon_pwr(mon_pwr),
    .pwr_tgt(pwr_tgt), .bias_trip(bias_trip), .pwr_trip(pwr_trip),
    .win_lo(win_lo), .win_hi(win_hi), .bias_code(bias_code),
    .laser_en(laser_en), .fault(fault), .bias_alarm(bias_alarm)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_bias = 0; m_str = 0; m_fault = 1'b0;
    end else begin
      bit upd;
      int nb, ns;
      bit nf;
      upd = (m_cnt == DIV - 1);
      nb = m_bias; ns = m_str; nf = m_fault;
      if (laser_off) ns = 0;
      else if (upd && !m_fault) begin
        if (m_bias > int'(bias_trip) || int'(mon_pwr) > int'(pwr_trip)) begin
          if (m_str >= 1) nf = 1'b1;
          else ns = m_str + 1;
        end else ns = 0;
      end
      if (laser_off || m_fault) nb = 0;
      else if (upd) begin
        if (int'(mon_pwr) + 1 < int'(pwr_tgt)) nb = (m_bias < MAXC) ? m_bias + 1 : MAXC;
        else if (int'(mon_pwr) > int'(pwr_tgt) + 1) nb = (m_bias > 0) ? m_bias - 1 : 0;
      end
      m_cnt = upd ? 0 : m_cnt + 1;
      m_bias = nb; m_str = ns; m_fault = nf;
    end
  end

  task automatic check(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int exp_en, exp_al;
    exp_en = (rst_n && !laser_off && !m_fault) ? 1 : 0;
    exp_al = (m_bias < int'(win_lo) || m_bias > int'(win_hi)) ? 1 : 0;
    check(int'(bias_code), m_bias, "R1/R2 bias_code");
    check(int'(fault), int'(m_fault), "R5 fault");
    check(int'(laser_en), exp_en, "R4 laser_en");
    check(int'(bias_alarm), exp_al, "R8 bias_alarm");
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
      if (plant) mon_pwr = PW'(m_bias / 2);
    end
  endtask

  task automatic to_update_edge();
    while (m_cnt != DIV - 1) step(1);
  endtask

  initial begin
    #(20 * 190000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R3: reset state
    step(3);
    check(int'(bias_code), 0, "R3 bias in reset");
    check(int'(fault), 0, "R3 fault in reset");
    check(int'(laser_en), 0, "R3 laser_en in reset");
    rst_n = 1'b1;

    // R1/R2: ramp from zero, one code per 16 cycles
    pwr_tgt = 10'd100; mon_pwr = 10'd0;
    step(DIV * 40);
    check(int'(bias_code), 40, "R1 ramp count after 40 updates");
    step(DIV - 1);
    check(int'(bias_code), 40, "R1 no change before next update");
    step(1);
    check(int'(bias_code), 41, "R1 change on update edge");

    // R2: closed loop through a bench plant (mon = bias/2)
    plant = 1'b1;
    step(DIV * 300);
    plant = 1'b0;
    check((int'(mon_pwr) >= 99 && int'(mon_pwr) <= 101) ? 1 : 0, 1, "R2 settled inside deadband");
    check(int'(bias_alarm), 0, "R8 alarm clear inside window");

    // R2: deadband edge holds
    begin
      int held;
      held = int'(bias_code);
      mon_pwr = 10'd101;
      step(DIV * 6);
      check(int'(bias_code), held, "R2 hold at tgt+1");
      mon_pwr = 10'd99;
      step(DIV * 6);
      check(int'(bias_code), held, "R2 hold at tgt-1");
      mon_pwr = 10'd102;
      step(DIV * 3);
      check(int'(bias_code), held - 3, "R2 step down above band");
    end

    // R9: saturation at zero
    mon_pwr = 10'd500;
    step(DIV * 260);
    check(int'(bias_code), 0, "R9 floor at zero");
    check(int'(bias_alarm), 1, "R8 alarm below window");

    // R4: disable
    mon_pwr = 10'd0;
    step(DIV * 20);
    laser_off = 1'b1;
    #1;
    check(int'(laser_en), 0, "R4 laser_en drops same cycle");
    step(1);
    check(int'(bias_code), 0, "R4 bias zero next edge");

    // R7: over-limit while off never faults
    pwr_trip = 10'd50; mon_pwr = 10'd300;
    step(DIV * 6);
    check(int'(fault), 0, "R7 no fault while disabled");
    mon_pwr = 10'd0; pwr_trip = '1;
    laser_off = 1'b0;
    step(DIV * 3);
    check(int'(bias_code), 3, "R4 ramp from zero after release");

    // R5: single over-limit update rejected
    pwr_tgt = 10'd400; pwr_trip = 10'd200;
    to_update_edge();
    mon_pwr = 10'd250;
    step(1);
    mon_pwr = 10'd0;
    step(DIV * 3);
    check(int'(fault), 0, "R5 single glitch ignored");

    // R5: two consecutive over-limit updates latch
    to_update_edge();
    mon_pwr = 10'd250;
    step(DIV + 1);
    check(int'(fault), 1, "R5 fault after two updates");
    check(int'(laser_en), 0, "R6 dark when faulted");
    mon_pwr = 10'd0;
    step(2);
    check(int'(bias_code), 0, "R6 bias zero when faulted");

    // R6: fault persists across clean input and disable toggles
    laser_off = 1'b1; step(DIV * 2);
    laser_off = 1'b0; step(DIV * 4);
    check(int'(fault), 1, "R6 fault persists");
    rst_n = 1'b0;
    #1;
    check(int'(fault), 0, "R6 reset clears fault");
    step(2);
    rst_n = 1'b1;

    // R5: bias trip path
    pwr_trip = '1; bias_trip = 10'd5; pwr_tgt = 10'd400;
    step(DIV * 8);
    check(int'(fault), 1, "R5 bias over trip latches");
    rst_n = 1'b0; step(2); rst_n = 1'b1;

    // R9: saturation at top
    bias_trip = '1; pwr_tgt = '1; mon_pwr = '0;
    step(DIV * (MAXC + 10));
    check(int'(bias_code), MAXC, "R9 ceiling at all-ones");
    check(int'(bias_alarm), 1, "R8 alarm above window");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule